// File: doc/BRIEF.md
# Alert Frame Transmit Buffer

This block keeps a short message that a host loads one byte at a time, and sends it as a single frame when the host asks. The host reaches it through a byte-wide register port that has four registers, picked by a 2-bit select: a write pointer, a data port that accepts writes only, a message length and a status register. Each data-port write stores the byte at the pointer and then advances the pointer, so a message can be loaded as a plain byte stream. Loading the pointer directly lets the host patch one byte.

Setting the go bit in the status register clears the pointer and starts a frame. The stored bytes leave from address 0 upward on a byte-wide valid/ready stream. Four check bytes follow them, computed on the fly with the Ethernet CRC-32. The go bit drops once the last check byte has been accepted. While a frame is in flight, the block flags a collision that the MAC reports after the first slot time.

The controller has three states. IDLE waits for the go bit. It takes GO_EMPTY back to IDLE, clearing the go bit, when the length is 0, and takes GO_SEND to SEND otherwise. SEND presents message bytes and takes DATA_END to CHECK when the last byte is accepted. CHECK presents the four check bytes and takes FRAME_END back to IDLE after the fourth.

Top module: `alert_tx_buffer`

## Requirements
- R1: After reset, the pointer (select 0), the data port (select 1), the length (select 2) and the status (select 3) all read 00h, and tx_valid is low.
- R2: A data-port write stores the byte at the pointer and then adds one to the pointer. The pointer reads back on select 0.
- R3: A host write to select 0 loads the pointer. A following data-port write changes only that one memory location.
- R4: Select 1 always reads 00h. Reading it leaves the pointer unchanged.
- R5: A status write with bit 7 set, made while idle, sets the go bit and clears the pointer to 0. The frame then carries memory bytes 0 to L-1 in order, where L is the length register.
- R6: After the data bytes come four bytes of ~CRC-32, least significant byte first. The CRC uses reflected polynomial 0xEDB88320 and is preset to all ones. tx_last is high only on the fourth check byte.
- R7: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold steady.
- R8: Status bit 7 reads 1 from the go write until the last check byte is accepted, and reads 0 afterwards. tx_valid is never high while it is 0.
- R9: A length of 0 sends no byte, and the go bit clears by itself.
- R10: A length above 128 sends exactly 128 data bytes.
- R11: Writes to select 0 or select 1 made while the go bit is set are ignored.
- R12: Status bits 6:4 and 2:0 always read 0.
- R13: Status bit 3 is set when mac_col is high while a frame is active and at least SLOT_BYTES (default 64) bytes have been accepted. A collision reported earlier in the frame is ignored. A go write clears bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Byte is valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| mac_col | input | 1 | Collision report from the MAC |

## Verification
The late-collision flag is the hardest case to reach. It needs a frame longer than one slot and a collision pulse that lands at a chosen byte count. The bench loads a 70-byte message and raises mac_col for one cycle once 10 bytes have been accepted, which must be ignored. In a second frame it raises mac_col after 66 bytes, which must set the flag. A go write with length 0 then shows that the flag clears.

// File: rtl/alert_tx_pkg.sv
package alert_tx_pkg;
    localparam logic [1:0] SEL_ADDR   = 2'd0;
    localparam logic [1:0] SEL_DATA   = 2'd1;
    localparam logic [1:0] SEL_LEN    = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_CHECK = 2'd2
    } tx_state_t;
endpackage

// File: rtl/alert_crc32_byte.sv
module alert_crc32_byte #(
    parameter logic [31:0] POLY_REFL = 32'hEDB88320
) (
    input  logic [31:0] crc_in,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc_out
);
    always_comb begin
        crc_out = crc_in ^ {24'd0, byte_in};
        for (int b = 0; b < 8; b++) begin
            crc_out = crc_out[0] ? ((crc_out >> 1) ^ POLY_REFL) : (crc_out >> 1);
        end
    end
endmodule

// File: rtl/alert_msg_mem.sv
module alert_msg_mem #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/alert_tx_buffer.sv
module alert_tx_buffer
    import alert_tx_pkg::*;
#(
    parameter int MEM_DEPTH  = 128,
    parameter int SLOT_BYTES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_sel,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    output logic       tx_last,
    input  logic       tx_ready,
    input  logic       mac_col
);
    localparam int         AW       = $clog2(MEM_DEPTH);
    localparam logic [7:0] DEPTH8   = 8'(MEM_DEPTH);
    localparam logic [7:0] SLOT8    = 8'(SLOT_BYTES);

    tx_state_t   state_q, state_d;
    logic [7:0]  wr_addr_q;
    logic [7:0]  len_q;
    logic [7:0]  len_run_q;
    logic [7:0]  rd_ptr_q;
    logic [1:0]  fcs_idx_q;
    logic [7:0]  sent_cnt_q;
    logic [31:0] crc_q;
    logic [31:0] crc_next;
    logic        start_q;
    logic        lcol_q;
    logic [7:0]  mem_rdata;
    logic [7:0]  len_eff;
    logic [31:0] fcs;
    logic        hs;
    logic        go_wr;
    logic        mem_we;
    logic        go_empty, go_send, data_end, frame_end;

    assign len_eff  = (len_q > DEPTH8) ? DEPTH8 : len_q;
    assign hs       = tx_valid && tx_ready;
    assign go_wr    = reg_wr && (reg_sel == SEL_STATUS) && reg_wdata[7] && !start_q;
    assign mem_we   = reg_wr && (reg_sel == SEL_DATA) && !start_q && (wr_addr_q < DEPTH8);
    assign fcs      = ~crc_q;
    assign go_empty = (state_q == ST_IDLE) && start_q && (len_eff == 8'd0);
    assign go_send  = (state_q == ST_IDLE) && start_q && (len_eff != 8'd0);
    assign data_end = (state_q == ST_SEND) && hs && (rd_ptr_q == len_run_q - 8'd1);
    assign frame_end = (state_q == ST_CHECK) && hs && (fcs_idx_q == 2'd3);

    alert_msg_mem #(.DEPTH(MEM_DEPTH), .WIDTH(8)) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_addr_q[AW-1:0]),
        .wdata (reg_wdata),
        .raddr (rd_ptr_q[AW-1:0]),
        .rdata (mem_rdata)
    );

    alert_crc32_byte crc_i (
        .crc_in  (crc_q),
        .byte_in (mem_rdata),
        .crc_out (crc_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go_send)   state_d = ST_SEND;
            ST_SEND:  if (data_end)  state_d = ST_CHECK;
            ST_CHECK: if (frame_end) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        tx_data  = 8'd0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_data  = mem_rdata;
            end
            ST_CHECK: begin
                tx_valid = 1'b1;
                tx_data  = fcs[8*fcs_idx_q +: 8];
                tx_last  = (fcs_idx_q == 2'd3);
            end
            default: ;
        endcase
    end

    // host registers and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr_q  <= 8'd0;
            len_q      <= 8'd0;
            len_run_q  <= 8'd0;
            rd_ptr_q   <= 8'd0;
            fcs_idx_q  <= 2'd0;
            sent_cnt_q <= 8'd0;
            crc_q      <= 32'hFFFF_FFFF;
            start_q    <= 1'b0;
            lcol_q     <= 1'b0;
        end else begin
            if (reg_wr && !start_q) begin
                unique case (reg_sel)
                    SEL_ADDR:   wr_addr_q <= reg_wdata;
                    SEL_DATA:   wr_addr_q <= wr_addr_q + 8'd1;
                    SEL_LEN:    len_q     <= reg_wdata;
                    SEL_STATUS: ;
                    default:    ;
                endcase
            end else if (reg_wr && reg_sel == SEL_LEN) begin
                len_q <= reg_wdata;
            end
            if (go_wr) begin
                start_q   <= 1'b1;
                wr_addr_q <= 8'd0;
                lcol_q    <= 1'b0;
            end
            if (go_empty || frame_end) begin
                start_q <= 1'b0;
            end
            if (go_send) begin
                len_run_q  <= len_eff;
                rd_ptr_q   <= 8'd0;
                fcs_idx_q  <= 2'd0;
                sent_cnt_q <= 8'd0;
                crc_q      <= 32'hFFFF_FFFF;
            end
            if (hs) begin
                sent_cnt_q <= sent_cnt_q + 8'd1;
                if (state_q == ST_SEND) begin
                    crc_q    <= crc_next;
                    rd_ptr_q <= rd_ptr_q + 8'd1;
                end else begin
                    fcs_idx_q <= fcs_idx_q + 2'd1;
                end
            end
            if (mac_col && state_q != ST_IDLE && sent_cnt_q >= SLOT8) begin
                lcol_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_ADDR:   reg_rdata = wr_addr_q;
            SEL_DATA:   reg_rdata = 8'd0;
            SEL_LEN:    reg_rdata = len_q;
            SEL_STATUS: reg_rdata = {start_q, 3'b000, lcol_q, 3'b000};
            default:    reg_rdata = 8'd0;
        endcase
    end
endmodule

// File: rtl/alert_tx_buffer_chk.sv
module alert_tx_buffer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_sel,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_last,
    input logic       tx_ready,
    input logic       start_q,
    input logic [7:0] wr_addr_q
);
    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R7

    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid); // R6

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel == 2'd3 |-> reg_rdata[6:4] == 3'd0 && reg_rdata[2:0] == 3'd0); // R12

    AST_GO_CLEARS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_sel == 2'd3 && reg_wdata[7] && !start_q |=> wr_addr_q == 8'd0); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q |-> !tx_valid); // R8

    AST_BUSY_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        start_q && reg_wr && (reg_sel == 2'd0 || reg_sel == 2'd1) |=> $stable(wr_addr_q)); // R11

    AST_DATA_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel == 2'd1 |-> reg_rdata == 8'd0); // R4
endmodule

bind alert_tx_buffer alert_tx_buffer_chk chk_i (.*);

// File: tb/alert_tx_buffer_tb_top.sv
module alert_tx_buffer_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_last;
    logic       tx_ready = 1'b0;
    logic       mac_col = 1'b0;

    int errors = 0;
    int checks = 0;
    logic [7:0] got [0:255];
    int nrx;
    int hold_bad;

    // len, seed, ready mask
    localparam logic [23:0] VECS [6] = '{
        {8'd1,   8'h10, 8'hFF},
        {8'd5,   8'h3C, 8'hA5},
        {8'd60,  8'h01, 8'hFF},
        {8'd128, 8'h77, 8'h6D},
        {8'd200, 8'hC2, 8'hFF},
        {8'd0,   8'h00, 8'hFF}
    };

    alert_tx_buffer dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (c[0] ^ got[i][b]) c = (c >> 1) ^ 32'hEDB88320;
                else                  c = c >> 1;
            end
        end
        return ~c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    // collect one frame; col_at >= 0 pulses mac_col when that many bytes are in
    task automatic collect(input logic [7:0] mask, input int col_at);
        logic [7:0] pd; logic pv; logic pl;
        pv = 1'b0; pd = 8'd0; pl = 1'b0;
        nrx = 0; hold_bad = 0;
        reg_sel = 2'd3;
        for (int cyc = 0; cyc < 2000; cyc++) begin
            @(negedge clk);
            tx_ready = mask[cyc % 8];
            mac_col = (col_at >= 0 && nrx == col_at && tx_valid);
            #1;
            if (pv && (!tx_valid || tx_data != pd || tx_last != pl)) hold_bad++;
            pv = tx_valid && !tx_ready; pd = tx_data; pl = tx_last;
            if (tx_valid && tx_ready) begin
                got[nrx] = tx_data;
                nrx++;
                if (tx_last) begin
                    @(negedge clk);
                    tx_ready = 1'b0; mac_col = 1'b0;
                    break;
                end
            end
            if (cyc > 1 && !reg_rdata[7]) break;
        end
        tx_ready = 1'b0; mac_col = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [31:0] f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            chk(v == 8'd0, "R1 reset read", v, 0);
        end
        chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);

        // CRC reference sanity ("123456789")
        for (int i = 0; i < 9; i++) got[i] = 8'h31 + 8'(i);
        f = ref_crc(9);
        chk(f == 32'hCBF43926, "R6 ref crc", f, 32'hCBF43926);

        // vector table
        foreach (VECS[k]) begin
            int len, nw, exp_n, bad;
            logic [7:0] seed, mask;
            len = int'(VECS[k][23:16]); seed = VECS[k][15:8]; mask = VECS[k][7:0];
            nw = (len > 128) ? 128 : len;
            exp_n = (nw == 0) ? 0 : nw + 4;
            wr(2'd0, 8'd0);
            for (int i = 0; i < nw; i++) wr(2'd1, seed + 8'(i * 37));
            wr(2'd2, 8'(len));
            wr(2'd3, 8'h80);
            collect(mask, -1);
            chk(nrx == exp_n, "R5/R9/R10 byte count", nrx, exp_n);
            bad = 0;
            for (int i = 0; i < nw && i < nrx; i++)
                if (got[i] != seed + 8'(i * 37)) bad++;
            chk(bad == 0, "R5 data order", bad, 0);
            if (nw > 0) begin
                f = ref_crc(nw);
                chk({got[nw+3], got[nw+2], got[nw+1], got[nw]} == f, "R6 fcs",
                    {got[nw+3], got[nw+2], got[nw+1], got[nw]}, f);
            end
            chk(hold_bad == 0, "R7 hold under stall", hold_bad, 0);
            rd(2'd3, v);
            chk(v[7] == 1'b0, "R8 go bit cleared", v, 0);
        end

        // R2 autoincrement
        wr(2'd0, 8'd10);
        wr(2'd1, 8'hAB); wr(2'd1, 8'hCD); wr(2'd1, 8'hEF);
        rd(2'd0, v);
        chk(v == 8'd13, "R2 address increment", v, 13);
        // R4 data port reads zero, no effect
        rd(2'd1, v);
        chk(v == 8'd0, "R4 data port read", v, 0);
        rd(2'd0, v);
        chk(v == 8'd13, "R4 address unchanged", v, 13);

        // R3 patch a single location
        wr(2'd0, 8'd0);
        wr(2'd1, 8'h01); wr(2'd1, 8'h02); wr(2'd1, 8'h03); wr(2'd1, 8'h04);
        wr(2'd0, 8'd2); wr(2'd1, 8'h55);
        wr(2'd2, 8'd4);
        wr(2'd3, 8'h80);
        // R11 writes while busy ignored; R5 address cleared
        wr(2'd0, 8'd9);
        wr(2'd1, 8'h99);
        rd(2'd0, v);
        chk(v == 8'd0, "R5/R11 address after go", v, 0);
        rd(2'd3, v);
        chk(v[7] == 1'b1, "R8 go bit while busy", v, 8'h80);
        collect(8'hFF, -1);
        chk(nrx == 8, "R3 frame size", nrx, 8);
        chk(got[0] == 8'h01 && got[1] == 8'h02 && got[2] == 8'h55 && got[3] == 8'h04,
            "R3/R11 patched content", {got[0], got[1], got[2], got[3]}, 32'h01025504);

        // R13 late collision
        wr(2'd0, 8'd0);
        for (int i = 0; i < 70; i++) wr(2'd1, 8'(i));
        wr(2'd2, 8'd70);
        wr(2'd3, 8'h80);
        collect(8'hFF, 10);
        rd(2'd3, v);
        chk(v[3] == 1'b0, "R13 early collision ignored", v, 0);
        wr(2'd3, 8'h80);
        collect(8'hFF, 66);
        rd(2'd3, v);
        chk(v == 8'h08, "R13 late collision flag / R12", v, 8'h08);
        wr(2'd2, 8'd0);
        wr(2'd3, 8'h80);
        collect(8'hFF, -1);
        chk(nrx == 0, "R9 empty frame", nrx, 0);
        rd(2'd3, v);
        chk(v == 8'h00, "R13 flag cleared by go", v, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule